// File: doc/BRIEF.md
# Two-Tier Memory Request Arbiter

This block decides which of four agents owns the memory bus next: an urgent display fetch, the processor, the graphics engine and a background display fetch. The urgent display fetch sits alone in a top tier and always wins. The other three agents share a lower tier. A single mode input sets how that tier is ordered. With the input low, the three agents take turns in a rotating order. With the input high, the processor ranks above the other two, and graphics and background display then take turns between themselves.

Each agent has a request line and a grant line. A grant is a registered one-hot output. Once a grant is issued it stays on until the owner pulses the shared completion input. In that same cycle the arbiter makes its next choice, so a new grant can follow the old one with no idle cycle between them. The block does not hold requests in a queue, decode addresses or carry data.

Top module: `mem_req_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with no requests, `gnt` is 4'b0000.
- R2: `gnt` has at most one bit set. The bits are: bit 0 urgent display, bit 1 processor, bit 2 graphics, bit 3 background display. The same bit order applies to `req`.
- R3: A decision is taken in any cycle where no grant is held, or where `done` is high while a grant is held. If `req[0]` is high in a decision cycle, the next cycle shows `gnt` = 4'b0001 in either mode.
- R4: With `rr_disable` = 0, the lower tier rotates in the order processor, graphics, background display. The search starts just after the lower-tier agent whose grant last completed. After reset it starts at the processor.
- R5: With `rr_disable` = 1, in a decision cycle where `req[0]` is low and `req[1]` is high, the next `gnt` is 4'b0010.
- R6: With `rr_disable` = 1 and the processor not requesting, graphics and background display alternate. The one that was not the most recent of the pair to complete goes first. After reset, graphics goes first.
- R7: While a grant is held and `done` is low, `gnt` does not change. This holds even if the urgent display starts requesting.
- R8: A decision cycle with no requests gives `gnt` = 0 in the next cycle. Idle cycles leave the rotation state unchanged.
- R9: A grant changes one clock after its decision cycle. When `done` completes a grant and another request is pending, the new grant appears in the very next cycle.
- R10: `done` has no effect while no grant is held.
- R11: A grant goes only to an agent whose request was high in the decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_disable | input | 1 | 0: lower tier rotates; 1: processor ranks first in the lower tier |
| req | input | 4 | Request per agent (bit order as in R2) |
| done | input | 1 | Current owner's transfer is complete |
| gnt | output | 4 | Registered one-hot grant |

## Verification
Two things can happen in the same cycle: a grant completes, and the next owner is chosen using the rotation state that this completion has just updated. The bench provokes this by raising `done` while several agents keep requesting, including the agent that is releasing, in both modes. The urgent display request is also made to arrive in that same cycle. A behavioural model tracks the owner and both rotation positions as integers, and the bench compares `gnt` with the model on every clock. A wrong rotation base therefore shows up as a wrong owner in the cycle right after the completion.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  localparam int NUM_AGENTS = 4;
  localparam int TIER_SIZE  = 3;            // processor, graphics, background display
  localparam int PAIR_SIZE  = 2;            // graphics, background display
  localparam int TIER_PW    = $clog2(TIER_SIZE);
  localparam int PAIR_PW    = $clog2(PAIR_SIZE);

  typedef enum logic [1:0] {
    AG_URGENT = 2'd0,
    AG_CPU    = 2'd1,
    AG_GFX    = 2'd2,
    AG_BGDISP = 2'd3
  } agent_e;
endpackage

// File: rtl/rot_picker.sv
module rot_picker #(
  parameter int N  = 3,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  input  logic [PW-1:0] start,
  output logic [N-1:0]  pick
);
  always_comb begin
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(start) + k) % N;
      if (!found && cand[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_ptr_state.sv
module arb_ptr_state
  import mem_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               release_en,
  input  logic [NUM_AGENTS-1:0] owner,
  output logic [TIER_PW-1:0] tier_eff,
  output logic [PAIR_PW-1:0] pair_eff
);
  logic [TIER_PW-1:0] tier_q, tier_d;
  logic [PAIR_PW-1:0] pair_q, pair_d;
  logic               tier_en, pair_en;

  // next-state: start just past the completing owner
  always_comb begin
    tier_d  = tier_q;
    pair_d  = pair_q;
    tier_en = 1'b0;
    pair_en = 1'b0;
    if (release_en) begin
      if (owner[AG_CPU]) begin
        tier_d  = TIER_PW'(1);
        tier_en = 1'b1;
      end
      if (owner[AG_GFX]) begin
        tier_d  = TIER_PW'(2);
        pair_d  = PAIR_PW'(1);
        tier_en = 1'b1;
        pair_en = 1'b1;
      end
      if (owner[AG_BGDISP]) begin
        tier_d  = TIER_PW'(0);
        pair_d  = PAIR_PW'(0);
        tier_en = 1'b1;
        pair_en = 1'b1;
      end
    end
  end

  assign tier_eff = tier_d;
  assign pair_eff = pair_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tier_q <= '0;
      pair_q <= '0;
    end else begin
      if (tier_en) tier_q <= tier_d;
      if (pair_en) pair_q <= pair_d;
    end
  end
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
  import mem_arb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rr_disable,
  input  logic [NUM_AGENTS-1:0] req,
  input  logic                  done,
  output logic [NUM_AGENTS-1:0] gnt
);
  logic [NUM_AGENTS-1:0] gnt_q, gnt_d, winner;
  logic                  busy, release_en, decide;
  logic [TIER_PW-1:0]    tier_eff;
  logic [PAIR_PW-1:0]    pair_eff;
  logic [TIER_SIZE-1:0]  tier_pick;
  logic [PAIR_SIZE-1:0]  pair_pick;

  assign busy       = |gnt_q;
  assign release_en = busy && done;
  assign decide     = !busy || done;

  arb_ptr_state u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .release_en (release_en),
    .owner      (gnt_q),
    .tier_eff   (tier_eff),
    .pair_eff   (pair_eff)
  );

  rot_picker #(.N(TIER_SIZE)) u_tier_pick (
    .cand  (req[NUM_AGENTS-1:1]),
    .start (tier_eff),
    .pick  (tier_pick)
  );

  rot_picker #(.N(PAIR_SIZE)) u_pair_pick (
    .cand  (req[NUM_AGENTS-1:2]),
    .start (pair_eff),
    .pick  (pair_pick)
  );

  always_comb begin
    winner = '0;
    if (req[AG_URGENT])  winner[AG_URGENT] = 1'b1;
    else if (!rr_disable) winner = {tier_pick, 1'b0};
    else if (req[AG_CPU]) winner[AG_CPU] = 1'b1;
    else                  winner = {pair_pick, 2'b00};
  end

  always_comb begin
    gnt_d = gnt_q;
    if (decide) gnt_d = winner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/mem_req_arbiter_chk.sv
module mem_req_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rr_disable,
  input logic [3:0] req,
  input logic       done,
  input logic [3:0] gnt
);
  logic dec;
  assign dec = (gnt == 4'b0000) || done;

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R7
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 4'b0000 && !done) |=> $stable(gnt));

  // R3
  urgent_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && req[0]) |=> gnt == 4'b0001);

  // R5
  cpu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && rr_disable && !req[0] && req[1]) |=> gnt == 4'b0010);

  // R8
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && req == 4'b0000) |=> gnt == 4'b0000);

  // R11
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && req != 4'b0000) |=> (gnt & $past(req)) != 4'b0000);
endmodule

bind mem_req_arbiter mem_req_arbiter_chk u_chk (.*);

// File: tb/mem_req_arbiter_test.sv
module mem_req_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rr_disable;
  logic [3:0] req;
  logic       done;
  logic [3:0] gnt;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // model state
  int m_own  = -1;   // -1 none, else agent index
  int m_tier = 0;    // next tier member to try (0 cpu,1 gfx,2 bg)
  int m_pair = 0;    // next pair member to try (0 gfx,1 bg)

  always #5 clk = ~clk;

  mem_req_arbiter uut (
    .clk(clk), .rst_n(rst_n), .rr_disable(rr_disable),
    .req(req), .done(done), .gnt(gnt)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gnt=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] m_gnt();
    return (m_own < 0) ? 4'b0000 : 4'(1 << m_own);
  endfunction

  // behavioural model: one clock
  task automatic model_clock(input logic [3:0] r, input logic d, input logic m);
    if (m_own >= 0 && d) begin
      if (m_own >= 1) m_tier = m_own % 3;        // member after owner
      if (m_own == 2) m_pair = 1;
      if (m_own == 3) m_pair = 0;
    end
    if (m_own < 0 || d) begin
      m_own = -1;
      if (r[0]) m_own = 0;
      else if (!m) begin
        for (int k = 0; k < 3; k++)
          if (m_own < 0 && r[1 + (m_tier + k) % 3]) m_own = 1 + (m_tier + k) % 3;
      end else if (r[1]) m_own = 1;
      else begin
        for (int k = 0; k < 2; k++)
          if (m_own < 0 && r[2 + (m_pair + k) % 2]) m_own = 2 + (m_pair + k) % 2;
      end
    end
  endtask

  task automatic step(input logic [3:0] r, input logic d, input logic m, input string tag);
    @(negedge clk);
    req = r; done = d; rr_disable = m;
    model_clock(r, d, m);
    @(posedge clk);
    #2;
    chk(tag, gnt, m_gnt());
  endtask

  // serve n grants with constant requests, one done per grant
  task automatic serve(input logic [3:0] r, input logic m, input int n, input string tag);
    for (int i = 0; i < n; i++) step(r, (gnt != 4'b0000), m, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 1'b0; req = '0; done = 1'b0; rr_disable = 1'b0;
    repeat (3) @(posedge clk);
    #2 chk("R1 in reset", gnt, 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    step(4'b0000, 1'b0, 1'b0, "R1 after reset");
    // R10: done while idle
    step(4'b0000, 1'b1, 1'b0, "R10");
    step(4'b0000, 1'b1, 1'b1, "R10");
    // R4 rotation, back-to-back R9
    step(4'b1110, 1'b0, 1'b0, "R9 first grant");
    chk("R4 processor first after reset", gnt, 4'b0010);
    step(4'b1110, 1'b1, 1'b0, "R9 back-to-back");
    chk("R4 graphics next", gnt, 4'b0100);
    step(4'b1110, 1'b1, 1'b0, "R4");
    chk("R4 background next", gnt, 4'b1000);
    serve(4'b1110, 1'b0, 5, "R4");
    // R7: hold, urgent arrives without preempting
    step(4'b1111, 1'b0, 1'b0, "R7 hold");
    step(4'b1111, 1'b0, 1'b0, "R7 hold");
    step(4'b1111, 1'b1, 1'b0, "R3 urgent at completion");
    chk("R3 urgent granted", gnt, 4'b0001);
    step(4'b0110, 1'b1, 1'b0, "R4 after urgent");
    // R8 idle keeps rotation
    step(4'b0000, 1'b1, 1'b0, "R8 release to idle");
    step(4'b0000, 1'b0, 1'b0, "R8 idle");
    step(4'b0000, 1'b0, 1'b0, "R8 idle");
    serve(4'b1110, 1'b0, 4, "R8 rotation kept");
    step(4'b0000, 1'b1, 1'b0, "R8");
    // R5 processor first
    serve(4'b1110, 1'b1, 4, "R5");
    step(4'b1110, 1'b1, 1'b1, "R5");
    chk("R5 processor wins", gnt, 4'b0010);
    // R6 pair alternation
    serve(4'b1100, 1'b1, 6, "R6");
    step(4'b1101, 1'b1, 1'b1, "R3 urgent in cpu-first mode");
    chk("R3 urgent in cpu-first mode", gnt, 4'b0001);
    serve(4'b1100, 1'b1, 4, "R6");
    step(4'b0000, 1'b1, 1'b1, "R8");
    // mixed traffic, R2 and R11
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[3:0], lfsr[4] | lfsr[6], (i >= 200), "R2 mixed traffic");
      checks++;
      if (!$onehot0(gnt)) begin
        fails++;
        $display("FAIL R2: gnt=%b expected at most one bit", gnt);
      end
    end
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule